// File: doc/BRIEF.md
# Power-Up Strap Sampling Sequencer

This block controls four dual-purpose pads on a clock generator. Three carry frequency-select straps and one carries a mode strap. At power-up each pad is an input whose level is set by an external resistor. After a fixed window the pads become clock outputs. The sequencer waits for a power-good indication, then counts a fixed number of reference-clock cycles while all four pad drivers stay in high impedance. When the count completes it captures the synchronized pad levels into sticky configuration registers. In the same cycle it enables the four output buffers.

The captured bits survive every event except a power cycle, which is modelled by the asynchronous power-on reset input. A power-good drop before capture restarts the window from zero. After capture the mode bit selects the role of a shared pad. With mode 1 the pad drives the reference clock out. With mode 0 it acts as the active-low stop input.

The window length `WIN_CYC` is a parameter. By default it is derived from the reference frequency in kHz and the window length in microseconds: 14318 kHz and 2000 us give 28636 cycles.

Top module: `strap_capture_seq`

## Requirements
- R1: While `por_n` is low, `fsel_o`=0, `mode_o`=0, `pin_oe`=4'b0000, `done_o`=0, `ref_pin_clk_o`=0 and `stop_pin_in_o`=0.
- R2: `pin_oe` is 4'b0000 for the whole time `done_o` is 0.
- R3: `done_o` rises on exactly the (`WIN_CYC`+2)-th rising clock edge after `pwr_good` goes high: two synchronizer edges plus `WIN_CYC` counting edges. It does not rise earlier.
- R4: At capture, `fsel_o` takes `pin_in[2:0]` (bit i goes to bit i) and `mode_o` takes `pin_in[3]`. The levels are those held on the pads during the window.
- R5: If `pwr_good` is low for at least one clock edge before capture, the count restarts from zero and nothing is captured. `done_o` then rises `WIN_CYC`+2 edges after `pwr_good` returns high.
- R6: After capture, changes on `pin_in` and drops of `pwr_good` leave `fsel_o`, `mode_o`, `done_o` and `pin_oe` unchanged.
- R7: Only `por_n` low clears the captured bits and `done_o`. After it is released, a new window captures the new pad levels.
- R8: After capture, `ref_pin_clk_o` equals `mode_o` and `stop_pin_in_o` equals the inverse of `mode_o`. Both are 0 before capture.
- R9: All four bits of `pin_oe` go to 1 on the same edge on which `done_o` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| por_n | input | 1 | Asynchronous active-low power-on reset (power cycle only) |
| pwr_good | input | 1 | Supply-valid indication, asynchronous |
| pin_in | input | 4 | Pad input levels: [2:0] frequency select, [3] mode |
| fsel_o | output | 3 | Latched frequency-select straps |
| mode_o | output | 1 | Latched mode strap |
| pin_oe | output | 4 | Per-pad output-buffer enable |
| done_o | output | 1 | Capture complete |
| ref_pin_clk_o | output | 1 | Shared pad acts as reference clock output |
| stop_pin_in_o | output | 1 | Shared pad acts as active-low stop input |

## Verification
Random strap patterns with both mode values show that each pad lands in its own bit, and that the mode decode follows the latched bit rather than the live pad. A power-good glitch placed at a random point inside the window separates a counter that restarts from one that resumes: only a restart puts the capture exactly `WIN_CYC`+2 edges after the final rise. Pad toggles and power-good drops after capture separate sticky latches from ones that keep tracking their inputs. A power-on reset followed by a new pattern shows that this reset alone clears the latched state.

// File: rtl/strap_seq_pkg.sv
package strap_seq_pkg;
  localparam int unsigned NUM_PADS = 4;
  localparam int unsigned NUM_FSEL = 3;

  typedef struct packed {
    logic       mode;
    logic [2:0] fsel;
  } strap_cfg_t;

  // Cycles of the reference clock in a window of win_us microseconds.
  function automatic int unsigned win_cycles(int unsigned ref_khz, int unsigned win_us);
    return (ref_khz * win_us) / 1000;
  endfunction

  function automatic logic ref_is_clk(logic done, logic mode);
    return done & mode;
  endfunction

  function automatic logic stop_is_in(logic done, logic mode);
    return done & ~mode;
  endfunction
endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
  parameter int unsigned W = 5
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
        meta[i] <= 1'b0;
        q[i]    <= 1'b0;
      end else begin
        meta[i] <= d[i];
        q[i]    <= meta[i];
      end
    end
  end
endmodule

// File: rtl/strap_timer.sv
module strap_timer #(
  parameter int unsigned WIN_CYC = 20,
  localparam int unsigned CW = $clog2(WIN_CYC + 1)
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          pg,
  input  logic          done_in,
  output logic          run,
  output logic          win_end,
  output logic [CW-1:0] cnt
);
  assign run     = pg && !done_in;
  assign win_end = run && (cnt == CW'(WIN_CYC - 1));

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)             cnt <= '0;
    else if (!run || win_end) cnt <= '0;
    else                    cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/strap_latch.sv
module strap_latch
  import strap_seq_pkg::*;
(
  input  logic       clk,
  input  logic       por_n,
  input  logic       cap,
  input  strap_cfg_t d,
  output strap_cfg_t cfg,
  output logic       done
);
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cfg  <= '0;
      done <= 1'b0;
    end else if (cap && !done) begin
      cfg  <= d;
      done <= 1'b1;
    end
  end
endmodule

// File: rtl/strap_capture_seq.sv
module strap_capture_seq
  import strap_seq_pkg::*;
#(
  parameter int unsigned REF_KHZ = 14318,
  parameter int unsigned WIN_US  = 2000,
  parameter int unsigned WIN_CYC = win_cycles(REF_KHZ, WIN_US),
  localparam int unsigned CW = $clog2(WIN_CYC + 1)
) (
  input  logic                clk,
  input  logic                por_n,
  input  logic                pwr_good,
  input  logic [NUM_PADS-1:0] pin_in,
  output logic [NUM_FSEL-1:0] fsel_o,
  output logic                mode_o,
  output logic [NUM_PADS-1:0] pin_oe,
  output logic                done_o,
  output logic                ref_pin_clk_o,
  output logic                stop_pin_in_o
);
  logic [NUM_PADS:0]   sync_q;
  logic [NUM_PADS-1:0] pins_s;
  logic                pg_s;
  logic                run;
  logic                win_end;
  logic [CW-1:0]       cnt;
  strap_cfg_t          cfg_q;
  logic                done;

  strap_sync #(.W(NUM_PADS + 1)) u_sync (
    .clk   (clk),
    .por_n (por_n),
    .d     ({pwr_good, pin_in}),
    .q     (sync_q)
  );

  assign pins_s = sync_q[NUM_PADS-1:0];
  assign pg_s   = sync_q[NUM_PADS];

  strap_timer #(.WIN_CYC(WIN_CYC)) u_timer (
    .clk     (clk),
    .por_n   (por_n),
    .pg      (pg_s),
    .done_in (done),
    .run     (run),
    .win_end (win_end),
    .cnt     (cnt)
  );

  strap_latch u_latch (
    .clk   (clk),
    .por_n (por_n),
    .cap   (win_end),
    .d     (strap_cfg_t'(pins_s)),
    .cfg   (cfg_q),
    .done  (done)
  );

  assign fsel_o        = cfg_q.fsel;
  assign mode_o        = cfg_q.mode;
  assign done_o        = done;
  assign pin_oe        = {NUM_PADS{done}};
  assign ref_pin_clk_o = ref_is_clk(done, cfg_q.mode);
  assign stop_pin_in_o = stop_is_in(done, cfg_q.mode);
endmodule

// File: rtl/strap_seq_chk.sv
module strap_seq_chk #(
  parameter int unsigned WIN_CYC = 20,
  parameter int unsigned CW = 5
) (
  input logic          clk,
  input logic          por_n,
  input logic          pg_s,
  input logic          run,
  input logic          win_end,
  input logic [CW-1:0] cnt,
  input logic [3:0]    pins_s,
  input logic [3:0]    cfg_q,
  input logic          done,
  input logic [3:0]    pin_oe,
  input logic          ref_pin_clk_o,
  input logic          stop_pin_in_o
);
  // R2
  oe_quiet_chk: assert property (@(posedge clk) disable iff (!por_n)
    run |-> pin_oe == 4'b0000);

  // R4
  capture_val_chk: assert property (@(posedge clk) disable iff (!por_n)
    win_end |=> cfg_q == $past(pins_s));

  // R5
  restart_chk: assert property (@(posedge clk) disable iff (!por_n)
    (!pg_s && !done) |=> cnt == '0);

  // R6
  sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
    done |=> done && $stable(cfg_q));

  // R8
  mode_dec_chk: assert property (@(posedge clk) disable iff (!por_n)
    done |-> (ref_pin_clk_o == cfg_q[3]) && (stop_pin_in_o == !cfg_q[3]));

  // R8
  pre_dec_chk: assert property (@(posedge clk) disable iff (!por_n)
    !done |-> !ref_pin_clk_o && !stop_pin_in_o);

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!por_n)
    cnt <= CW'(WIN_CYC - 1));

  // R9
  oe_rise_chk: assert property (@(posedge clk) disable iff (!por_n)
    $rose(done) |-> pin_oe == 4'b1111);
endmodule

bind strap_capture_seq strap_seq_chk #(.WIN_CYC(WIN_CYC), .CW(CW)) u_chk (
  .clk           (clk),
  .por_n         (por_n),
  .pg_s          (pg_s),
  .run           (run),
  .win_end       (win_end),
  .cnt           (cnt),
  .pins_s        (pins_s),
  .cfg_q         (cfg_q),
  .done          (done),
  .pin_oe        (pin_oe),
  .ref_pin_clk_o (ref_pin_clk_o),
  .stop_pin_in_o (stop_pin_in_o)
);

// File: tb/tb_strap_capture_seq.sv
module tb_strap_capture_seq;
  localparam int unsigned WIN = 20;

  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       pwr_good = 1'b0;
  logic [3:0] pin_in = 4'b0000;
  logic [2:0] fsel_o;
  logic       mode_o;
  logic [3:0] pin_oe;
  logic       done_o;
  logic       ref_pin_clk_o;
  logic       stop_pin_in_o;

  int n_vec = 0;
  int n_bad = 0;

  strap_capture_seq #(.WIN_CYC(WIN)) dut (
    .clk(clk), .por_n(por_n), .pwr_good(pwr_good), .pin_in(pin_in),
    .fsel_o(fsel_o), .mode_o(mode_o), .pin_oe(pin_oe), .done_o(done_o),
    .ref_pin_clk_o(ref_pin_clk_o), .stop_pin_in_o(stop_pin_in_o)
  );

  always #4 clk = ~clk;

  // Expected port picture {ref,stop,done,oe[3:0],mode,fsel[2:0]} from requirements.
  function automatic logic [11:0] expect_cfg(logic d, logic [3:0] straps);
    logic m;
    m = d ? straps[3] : 1'b0;
    return {d & m, d & ~m, d, {4{d}}, m, (d ? straps[2:0] : 3'b000)};
  endfunction

  function automatic logic [11:0] observed();
    return {ref_pin_clk_o, stop_pin_in_o, done_o, pin_oe, mode_o, fsel_o};
  endfunction

  task automatic check(string req, logic [11:0] act, logic [11:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%03h expected=%03h", req, act, exp);
    end
  endtask

  task automatic edges(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic power_cycle(logic [3:0] straps);
    @(negedge clk);
    por_n = 1'b0;
    pwr_good = 1'b0;
    pin_in = straps;
    edges(2);
    check("R1/R7 cleared by power-on reset", observed(), expect_cfg(1'b0, 4'b0000));
    por_n = 1'b1;
    edges(1);
  endtask

  // Raises power-good and checks the capture edge exactly.
  task automatic window(string req, logic [3:0] straps);
    pwr_good = 1'b1;
    edges(WIN + 1);
    check({req, " R2/R3 not done one edge early"}, observed(), expect_cfg(1'b0, straps));
    edges(1);
    check({req, " R3/R4/R8/R9 captured"}, observed(), expect_cfg(1'b1, straps));
  endtask

  initial begin
    logic [3:0] s;
    process::self().srandom(32'd2024);

    // Directed: reset state, mode 1 pattern.
    s = 4'b1010;
    power_cycle(s);
    pwr_good = 1'b1;
    edges(WIN / 2);
    check("R2 mid-window outputs quiet", observed(), expect_cfg(1'b0, s));
    pwr_good = 1'b0;
    edges(2);
    window("R5 restart after mid-window drop", s);

    // R6: pad toggles and power-good drop after capture are ignored.
    pin_in = ~s;
    pwr_good = 1'b0;
    edges(30);
    check("R6 latched after pads and power-good change", observed(), expect_cfg(1'b1, s));

    // R7: new power cycle, mode 0, glitch mid-window.
    s = 4'b0101;
    power_cycle(s);
    pwr_good = 1'b1;
    edges(5);
    pwr_good = 1'b0;
    edges(3);
    check("R5 nothing captured during drop", observed(), expect_cfg(1'b0, s));
    window("R5/R7/R8 mode0", s);

    // Corners: all zero and all one straps.
    power_cycle(4'b0000);
    window("R4 all-zero", 4'b0000);
    power_cycle(4'b1111);
    window("R4 all-one", 4'b1111);

    // Random patterns with random glitch placement.
    for (int it = 0; it < 12; it++) begin
      int g;
      int len;
      s = 4'($urandom);
      power_cycle(s);
      if ($urandom % 2 == 1) begin
        g = int'($urandom % WIN);
        len = 1 + int'($urandom % 4);
        pwr_good = 1'b1;
        edges(g);
        pwr_good = 1'b0;
        edges(len);
      end
      window("R3/R4/R5 random", s);
      pin_in = 4'($urandom);
      if ($urandom % 2 == 1) pwr_good = 1'b0;
      edges(1 + int'($urandom % 8));
      check("R6 random post-capture change", observed(), expect_cfg(1'b1, s));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 8);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule